// File: doc/BRIEF.md
# Four-Word Mailbox Message Sequencer

This block runs the requester side of a four-channel mailbox. A caller gives it a payload address, a payload length and a response timeout, then pulses `start`. The block builds a four-word request frame and writes it out. Each word goes to its own transmit channel, and the block waits for that channel to report empty before each write. If a reply is wanted, the block can first wait for receive channel 0 to fill. It then reads one reply word from each of the four receive channels in turn.

Each request carries a sequence id that the block keeps itself, plus a fixed request type code. Every wait is bounded. A wait that runs out ends the transaction with a timeout flag. A request with bad arguments is refused before anything moves. Two enable inputs choose the mode: send then receive, send only, or receive only. The transaction ends with a one-cycle done pulse. The reply words are on the `reply` output when that pulse arrives.

Top module: `mbox_msg_seq`

## Requirements
- R1: A request frame is written as four words, one per cycle at most, in channel order 0, 1, 2, 3, with `tx_wr` one-hot on the channel written. The word on channel 0 is the sequence id. Channel 1 carries the type code 0x1, which means a request. Channel 2 carries `payload_addr` and channel 3 carries `payload_len`.
- R2: A word is written to channel n only in a cycle where `tx_empty[n]` is high. No two strobes in `tx_wr` or `rx_rd` are ever active together.
- R3: The sequence id is 0 after reset. It increments by one each time channel 0 accepts a word. A transaction that aborts before channel 0 accepts a word leaves the id unchanged.
- R4: If a channel flag stays low for WORD_TMO consecutive cycles while the block waits on it, the transaction ends with `done` and `err_timeout` high.
- R5: When receiving with a nonzero `resp_tmo`, the block first waits up to `resp_tmo` cycles for `rx_full[0]`. If the wait expires, the transaction ends with `err_timeout`. Otherwise the block reads channels 0 to 3 in order, pulsing `rx_rd[n]` only while `rx_full[n]` is high. Word n of the reply is placed at `reply[32n+31:32n]`.
- R6: A `resp_tmo` of zero skips the initial wait on channel 0. The per-word reads still occur.
- R7: When `start` arrives with `resp_tmo[31]` set (a negative value) or with both enables low, the request is rejected. The block gives `done` with `err_arg` on the next cycle and sends or reads nothing.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted `start` until `done`. A `start` while `busy` is ignored.
- R9: With `send_en` high and `recv_en` low, the block reads no receive channel. With `send_en` low and `recv_en` high, it writes no transmit channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| send_en | input | 1 | Send the request frame |
| recv_en | input | 1 | Collect a reply frame |
| payload_addr | input | 32 | Payload address placed in word 2 |
| payload_len | input | 32 | Payload length placed in word 3 |
| resp_tmo | input | 32 | Signed response timeout in cycles; 0 skips the wait |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err_timeout | output | 1 | Transaction ended on an expired wait (valid with done) |
| err_arg | output | 1 | Request rejected for bad arguments (valid with done) |
| tx_empty | input | 4 | Per-channel transmit-empty flags |
| tx_wr | output | 4 | Per-channel transmit write strobes |
| tx_data | output | 32 | Word being written |
| rx_full | input | 4 | Per-channel receive-full flags |
| rx_rd | output | 4 | Per-channel receive read strobes |
| rx_data | input | 128 | Receive channel words, channel n at bits 32n+31:32n |
| reply | output | 128 | Collected reply, word n at bits 32n+31:32n |

## Verification
The bound checker checks the handshake rules on every cycle. It confirms that no write happens without the empty flag and no read happens without the full flag, and that at most one strobe is active at a time. It also checks that the type word rides on channel 1, that the sequence id steps only on a channel 0 write, that `done` is a single-cycle pulse, and that the error flags only appear with it. Some behaviour needs whole scenarios from the bench. These are the word contents and their order, the id carried across aborted and rejected requests, the length of each timeout, skipping the response wait, the choice of mode, and a `start` being ignored while busy.

// File: rtl/mbox_msg_seq.sv
module mbox_msg_seq #(
  parameter int DW       = 32,
  parameter int WORD_TMO = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            send_en,
  input  logic            recv_en,
  input  logic [DW-1:0]   payload_addr,
  input  logic [DW-1:0]   payload_len,
  input  logic [DW-1:0]   resp_tmo,
  output logic            busy,
  output logic            done,
  output logic            err_timeout,
  output logic            err_arg,
  input  logic [3:0]      tx_empty,
  output logic [3:0]      tx_wr,
  output logic [DW-1:0]   tx_data,
  input  logic [3:0]      rx_full,
  output logic [3:0]      rx_rd,
  input  logic [4*DW-1:0] rx_data,
  output logic [4*DW-1:0] reply
);

  localparam logic [DW-1:0] TYPE_REQ = DW'(1);
  localparam logic [DW-1:0] WLIM     = DW'(WORD_TMO - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_RWAIT, S_RECV} st_t;

  st_t            st;
  logic [1:0]     idx;
  logic [DW-1:0]  cnt, seq_q, addr_q, len_q, tmo_q;
  logic           rcv_q, done_q, etmo_q, earg_q;
  logic [4*DW-1:0] reply_q;
  logic [DW-1:0]  word_sel;
  logic           tx_fire, rx_fire, bad_args;

  always_comb begin
    case (idx)
      2'd0:    word_sel = seq_q;
      2'd1:    word_sel = TYPE_REQ;
      2'd2:    word_sel = addr_q;
      default: word_sel = len_q;
    endcase
  end

  assign tx_fire  = (st == S_SEND) && tx_empty[idx];
  assign rx_fire  = (st == S_RECV) && rx_full[idx];
  assign tx_wr    = tx_fire ? (4'b0001 << idx) : 4'b0000;
  assign rx_rd    = rx_fire ? (4'b0001 << idx) : 4'b0000;
  assign tx_data  = word_sel;
  assign bad_args = resp_tmo[DW-1] || !(send_en || recv_en);

  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign err_timeout = etmo_q;
  assign err_arg     = earg_q;
  assign reply       = reply_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      cnt     <= '0;
      seq_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      tmo_q   <= '0;
      rcv_q   <= 1'b0;
      done_q  <= 1'b0;
      etmo_q  <= 1'b0;
      earg_q  <= 1'b0;
      reply_q <= '0;
    end else begin
      done_q <= 1'b0;
      etmo_q <= 1'b0;
      earg_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (bad_args) begin
              done_q <= 1'b1;
              earg_q <= 1'b1;
            end else begin
              addr_q <= payload_addr;
              len_q  <= payload_len;
              tmo_q  <= resp_tmo;
              rcv_q  <= recv_en;
              idx    <= '0;
              cnt    <= '0;
              if (send_en)              st <= S_SEND;
              else if (resp_tmo != '0)  st <= S_RWAIT;
              else                      st <= S_RECV;
            end
          end
        end
        S_SEND: begin
          if (tx_fire) begin
            cnt <= '0;
            if (idx == 2'd0) seq_q <= seq_q + DW'(1);
            idx <= idx + 2'd1;
            if (idx == 2'd3) begin
              if (!rcv_q) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
              end else if (tmo_q != '0) begin
                st <= S_RWAIT;
              end else begin
                st <= S_RECV;
              end
            end
          end else if (cnt == WLIM) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            etmo_q <= 1'b1;
          end else begin
            cnt <= cnt + DW'(1);
          end
        end
        S_RWAIT: begin
          if (rx_full[0]) begin
            st  <= S_RECV;
            cnt <= '0;
          end else if (cnt == tmo_q - DW'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            etmo_q <= 1'b1;
          end else begin
            cnt <= cnt + DW'(1);
          end
        end
        S_RECV: begin
          if (rx_fire) begin
            reply_q[idx*DW +: DW] <= rx_data[idx*DW +: DW];
            cnt <= '0;
            idx <= idx + 2'd1;
            if (idx == 2'd3) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end else if (cnt == WLIM) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            etmo_q <= 1'b1;
          end else begin
            cnt <= cnt + DW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_msg_seq_chk.sv
module mbox_msg_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    tx_wr,
  input logic [3:0]    tx_empty,
  input logic [3:0]    rx_rd,
  input logic [3:0]    rx_full,
  input logic [DW-1:0] tx_data,
  input logic          done,
  input logic          err_timeout,
  input logic          err_arg,
  input logic          busy,
  input logic [DW-1:0] seq_q
);

  AST_WR_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr & ~tx_empty) == 4'b0000);                                       // R2
  AST_RD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd & ~rx_full) == 4'b0000);                                        // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_wr, rx_rd}));                                             // R2
  AST_TYPE_ON_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr[1] |-> tx_data == DW'(1));                                       // R1
  AST_SEQ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr[0] |=> seq_q == $past(seq_q) + DW'(1));                          // R3
  AST_SEQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr[0] |=> $stable(seq_q));                                         // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                       // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout || err_arg) |-> done);                                    // R4
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_timeout && err_arg));                                            // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_wr == 4'b0000 && rx_rd == 4'b0000));                     // R8

endmodule

bind mbox_msg_seq mbox_msg_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
  .rx_rd(rx_rd), .rx_full(rx_full), .tx_data(tx_data), .done(done),
  .err_timeout(err_timeout), .err_arg(err_arg), .busy(busy), .seq_q(seq_q)
);

// File: tb/mbox_msg_seq_bench.sv
`timescale 1ns/1ps
module mbox_msg_seq_bench;
  localparam int DW = 32;
  localparam int WT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, send_en = 0, recv_en = 0;
  logic [31:0] payload_addr = 0, payload_len = 0, resp_tmo = 0;
  logic busy, done, err_timeout, err_arg;
  logic [3:0] tx_empty, tx_wr, rx_full, rx_rd;
  logic [31:0] tx_data;
  logic [127:0] rx_data, reply;

  logic [3:0] tx_block = 4'b0000;
  logic [3:0] rx_set = 4'b0000;
  logic [3:0] rx_clr = 4'b0000;
  logic [31:0] wr_word [4];
  logic [1:0]  wr_ch [8];
  int wr_n = 0, rd_n = 0;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [31:0] exp_seq = 0;

  always #4 clk = ~clk;

  assign tx_empty = ~tx_block;

  mbox_msg_seq #(.DW(DW), .WORD_TMO(WT)) u_mbox_msg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .send_en(send_en), .recv_en(recv_en),
    .payload_addr(payload_addr), .payload_len(payload_len), .resp_tmo(resp_tmo),
    .busy(busy), .done(done), .err_timeout(err_timeout), .err_arg(err_arg),
    .tx_empty(tx_empty), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_full(rx_full), .rx_rd(rx_rd), .rx_data(rx_data), .reply(reply));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (tx_wr[i]) begin
        wr_word[i] <= tx_data;
        if (wr_n < 8) wr_ch[wr_n] <= 2'(i);
        wr_n <= wr_n + 1;
      end
    end
    if (rx_rd != 4'b0000) rd_n <= rd_n + 1;
    rx_clr <= rx_clr | rx_rd;
  end

  assign rx_full = rx_set & ~rx_clr;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    wr_n = 0; rd_n = 0; rx_set = 4'b0000; rx_clr = 4'b0000; tx_block = 4'b0000;
  endtask

  task automatic pulse_start(input bit s, input bit r, input logic [31:0] a, input logic [31:0] l, input logic [31:0] t);
    @(negedge clk);
    send_en = s; recv_en = r; payload_addr = a; payload_len = l; resp_tmo = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 1;
    while (!done && cycles < 400) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic load_reply(input logic [31:0] w0, w1, w2, w3);
    rx_data = {w3, w2, w1, w0};
    rx_set = 4'b1111;
  endtask

  task automatic t_reset();
    check(!busy && !done && tx_wr == 0 && rx_rd == 0, "R8 reset idle", {busy, done, tx_wr, rx_rd}, 0);
  endtask

  task automatic t_send(input logic [31:0] a, input logic [31:0] l);
    int c;
    clear_log();
    pulse_start(1, 0, a, l, 0);
    wait_done(c);
    check(done && !err_timeout && !err_arg, "R1 send done clean", {err_timeout, err_arg, done}, 1);
    check(wr_n == 4, "R1 four writes", wr_n, 4);
    check(wr_word[0] == exp_seq, "R3 sequence id", wr_word[0], exp_seq);
    check(wr_word[1] == 32'h1 && wr_word[2] == a && wr_word[3] == l, "R1 frame words",
          {wr_word[1], wr_word[2], wr_word[3]}, {32'h1, a, l});
    check(wr_ch[0] == 0 && wr_ch[1] == 1 && wr_ch[2] == 2 && wr_ch[3] == 3, "R1 channel order",
          {wr_ch[0], wr_ch[1], wr_ch[2], wr_ch[3]}, 8'h1b);
    exp_seq++;
    @(negedge clk);
    check(!done, "R8 done single pulse", done, 0);
  endtask

  task automatic t_send_recv();
    int c;
    clear_log();
    load_reply(32'd7, 32'h2, 32'hCAFE0000, 32'd99);
    pulse_start(1, 1, 32'h8000_1000, 32'd12, 32'd50);
    wait_done(c);
    check(done && !err_timeout && !err_arg, "R5 exchange clean", {err_timeout, err_arg}, 0);
    check(reply == {32'd99, 32'hCAFE0000, 32'h2, 32'd7}, "R5 reply words", reply,
          {32'd99, 32'hCAFE0000, 32'h2, 32'd7});
    check(wr_n == 4 && rd_n == 4 && wr_word[0] == exp_seq, "R5 frame then reply", {wr_n, rd_n, wr_word[0]}, {32'd4, 32'd4, exp_seq});
    exp_seq++;
  endtask

  task automatic t_recv_only_zero_tmo();
    int c;
    clear_log();
    load_reply(32'h11, 32'h22, 32'h33, 32'h44);
    pulse_start(0, 1, 32'h0, 32'h0, 32'd0);
    wait_done(c);
    check(done && !err_timeout, "R6 zero timeout reads", {done, err_timeout}, 2'b10);
    check(reply == {32'h44, 32'h33, 32'h22, 32'h11}, "R6 reply", reply, {32'h44, 32'h33, 32'h22, 32'h11});
    check(wr_n == 0, "R9 receive-only writes nothing", wr_n, 0);
  endtask

  task automatic t_send_only_no_read();
    int c;
    clear_log();
    load_reply(32'h1, 32'h2, 32'h3, 32'h4);
    pulse_start(1, 0, 32'h55, 32'h66, 32'd10);
    wait_done(c);
    check(rd_n == 0 && rx_full == 4'b1111, "R9 send-only reads nothing", {rd_n, rx_full}, {32'd0, 4'hf});
    exp_seq++;
  endtask

  task automatic t_bad_args();
    int c;
    clear_log();
    pulse_start(1, 1, 32'h1, 32'h2, 32'hFFFF_FFF0);
    check(done && err_arg && !err_timeout && !busy, "R7 negative timeout rejected", {done, err_arg, err_timeout, busy}, 4'b1100);
    repeat (3) @(negedge clk);
    check(wr_n == 0 && rd_n == 0, "R7 nothing sent", {wr_n, rd_n}, 0);
    pulse_start(0, 0, 32'h1, 32'h2, 32'd5);
    check(done && err_arg, "R7 no mode rejected", {done, err_arg}, 2'b11);
    c = 0;
  endtask

  task automatic t_tx_timeout_mid();
    int c;
    clear_log();
    tx_block = 4'b0100;
    pulse_start(1, 0, 32'hA, 32'hB, 0);
    wait_done(c);
    check(done && err_timeout && !err_arg, "R4 word timeout", {done, err_timeout, err_arg}, 3'b110);
    check(wr_n == 2, "R4 aborted after two words", wr_n, 2);
    check(c >= WT, "R4 waited full window", c, WT);
    exp_seq++;
  endtask

  task automatic t_tx_timeout_first();
    int c;
    clear_log();
    tx_block = 4'b0001;
    pulse_start(1, 0, 32'hA, 32'hB, 0);
    wait_done(c);
    check(err_timeout && wr_n == 0, "R3 abort before word 0", {err_timeout, wr_n}, {1'b1, 32'd0});
  endtask

  task automatic t_resp_timeout();
    int c;
    clear_log();
    pulse_start(0, 1, 0, 0, 32'd40);
    wait_done(c);
    check(done && err_timeout, "R5 response timeout", {done, err_timeout}, 2'b11);
    check(c >= 40 && c <= 43, "R5 timeout length", c, 40);
    check(rd_n == 0, "R5 no reads on timeout", rd_n, 0);
  endtask

  task automatic t_busy_ignore();
    int c;
    clear_log();
    tx_block = 4'b1000;
    pulse_start(1, 0, 32'h77, 32'h88, 0);
    check(busy, "R8 busy after start", busy, 1);
    repeat (3) @(negedge clk);
    pulse_start(1, 0, 32'h99, 32'h99, 0);
    tx_block = 4'b0000;
    wait_done(c);
    check(done && !err_timeout && wr_n == 4, "R8 first request completes", {done, err_timeout, wr_n}, {2'b10, 32'd4});
    exp_seq++;
    repeat (20) @(negedge clk);
    check(wr_n == 4 && !busy, "R8 start while busy ignored", {wr_n, busy}, {32'd4, 1'b0});
  endtask

  initial begin
    rx_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send(32'h1000_0000, 32'd64);
    t_send(32'h2000_0040, 32'd8);
    t_send_recv();
    t_recv_only_zero_tmo();
    t_send_only_no_read();
    t_bad_args();
    t_tx_timeout_mid();
    t_tx_timeout_first();
    t_send(32'h3000_0000, 32'd1);
    t_resp_timeout();
    t_busy_ignore();
    t_send(32'h4000_0000, 32'd2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule